// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides whether a received Ethernet frame is kept, based only on its 48-bit destination address. The address enters one byte per accepted beat, first byte on the wire first, with a start strobe on the first byte. When all six bytes have arrived, the block returns a one-cycle decision: accept or reject, plus a code that names the rule that matched.

Two tables drive the decision. The first holds sixteen exact-match slots. By convention slot 0 holds the station's own address. The second is a 512-bit multicast hash table, indexed by nine bits of a CRC-32 over the address. Three mode bits widen acceptance: promiscuous, all-multicast and broadcast. All tables and mode bits are loaded through a 16-bit register write port.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, dec_valid, dec_accept and dec_source are 0, all table words are 0 and all three mode bits are clear.
- R2: An address is six bytes accepted on da_valid, the first with da_sof high. Idle cycles may fall between bytes. dec_valid pulses for exactly one cycle, registered at the clock edge after the edge that samples the sixth byte. Further bytes without da_sof are ignored until the next da_sof.
- R3: A da_sof in the middle of an address discards the partial address and starts a new one with that byte.
- R4: cfg_addr bit 6 = 0 selects exact slot cfg_addr[5:2] and word cfg_addr[1:0]. Word 0 holds address bytes 5,4 (the last halfword), word 1 holds bytes 3,2, and word 2 holds bytes 1,0, with the earlier byte in bits 15:8. Word 3 is ignored. A destination equal to a slot gives accept with source 1.
- R5: A slot whose 48 bits are all zero never matches.
- R6: The hash index is bits [31:23] of a CRC-32. The CRC starts at 0xFFFFFFFF and is fed the six bytes in arrival order, each least significant bit first. For each bit, the register shifts left and XORs in 0x04C11DB7 when its old bit 31 XOR the data bit is 1. Hash word index[8:4] is written at cfg_addr 0x40 + index[8:4], and bit index[3:0] of that word is the entry. A multicast destination (bit 0 of the first byte set) whose entry is 1 gives accept with source 2.
- R7: Mode register at cfg_addr 0x60 uses bit 2 for broadcast, bit 1 for all-multicast and bit 0 for promiscuous. With bit 2 set, the all-ones address gives source 3. With bit 2 clear, the all-ones address is rejected unless promiscuous mode is on.
- R8: With promiscuous mode on, every destination is accepted. The source is 4 unless an exact, broadcast or hash rule matched first.
- R9: With all-multicast mode on, every multicast destination that is not all-ones is accepted with source 4 if no exact or hash rule matched. Unicast destinations are not affected.
- R10: Rules apply in the order exact (1), broadcast (3), hash (2), then promiscuous/all-multicast (4). No match gives source 0 and reject. dec_accept is 1 exactly when dec_source is not 0.
- R11: The hash table never accepts a unicast destination. Writing zero to a hash word removes every hash match that depended on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 7 | Register word address |
| cfg_wdata | input | 16 | Register write data |
| da_valid | input | 1 | Address byte valid |
| da_sof | input | 1 | First byte of a destination address |
| da_byte | input | 8 | Address byte |
| dec_valid | output | 1 | Decision valid, one-cycle pulse |
| dec_accept | output | 1 | Frame accepted |
| dec_source | output | 3 | Matching rule: 0 none, 1 exact, 2 hash, 3 broadcast, 4 promiscuous/all-multicast |

## Verification
The decision is due one clock edge after the edge that samples the sixth byte. The bench checks that dec_valid is still low at the falling edge just after that sampling edge. It then reads accept and source at the following falling edge and confirms the pulse has gone at the falling edge after that. Register writes land at the edge that samples them, so every write completes before the first byte of the next address is driven. For the trailing-byte and restart cases, the bench counts decision pulses across a window of falling edges, so that a late or extra pulse is also seen.

// File: rtl/rxf_pkg.sv
// Shared types and the CRC step for the receive address filter.
// Assumes bytes are fed least significant bit first.
package rxf_pkg;

    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;

    typedef enum logic [2:0] {
        SRC_NONE  = 3'd0,
        SRC_EXACT = 3'd1,
        SRC_HASH  = 3'd2,
        SRC_BCAST = 3'd3,
        SRC_OPEN  = 3'd4
    } match_src_e;

    // Advance a CRC-32 register by one byte, LSB first.
    function automatic logic [31:0] crc_byte(input logic [31:0] cur, input logic [7:0] dat);
        logic [31:0] r;
        logic        fb;
        r = cur;
        for (int k = 0; k < 8; k++) begin
            fb = r[31] ^ dat[k];
            r  = {r[30:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

endpackage

// File: rtl/rxf_addr_capture.sv
// Collects the destination address bytes and computes the hash CRC
// byte-serially. A start strobe restarts collection; bytes after the
// last one are ignored until the next start. done_q pulses for one
// cycle once the address is complete.
module rxf_addr_capture #(
    parameter int BYTES = 6,
    parameter int IDX_W = 9,
    localparam int AW    = 8 * BYTES,
    localparam int CNT_W = $clog2(BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_vld,
    input  logic             byte_sof,
    input  logic [7:0]       byte_dat,
    output logic [AW-1:0]    addr_q,
    output logic [IDX_W-1:0] hash_idx,
    output logic             done_q
);
    import rxf_pkg::*;

    logic [CNT_W-1:0] cnt_q;
    logic [31:0]      crc_q;

    // Byte counter, address shift register and running CRC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            addr_q <= '0;
            crc_q  <= CRC_SEED;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (byte_vld && byte_sof) begin
                cnt_q  <= CNT_W'(1);
                addr_q <= {{(AW-8){1'b0}}, byte_dat};
                crc_q  <= crc_byte(CRC_SEED, byte_dat);
            end else if (byte_vld && cnt_q != '0 && cnt_q < CNT_W'(BYTES)) begin
                cnt_q  <= cnt_q + CNT_W'(1);
                addr_q <= {addr_q[AW-9:0], byte_dat};
                crc_q  <= crc_byte(crc_q, byte_dat);
                if (cnt_q == CNT_W'(BYTES - 1)) done_q <= 1'b1;
            end
        end
    end

    // Hash index is taken from the top CRC bits.
    assign hash_idx = crc_q[31 -: IDX_W];

    // R2
    single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(BYTES));

endmodule

// File: rtl/rxf_exact_table.sv
// Exact-match slots, each written as 16-bit words (word 0 = last
// halfword). A slot that is all zero is treated as empty.
module rxf_exact_table #(
    parameter int SLOTS  = 16,
    parameter int WORD_W = 16,
    parameter int WORDS  = 3,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int KEY_W  = WORD_W * WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [1:0]        wr_word,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [KEY_W-1:0]  key,
    output logic              hit
);
    logic [SLOTS-1:0] hits;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [WORD_W-1:0] words [WORDS];
        logic [KEY_W-1:0]  flat;

        // Load one word of this slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int w = 0; w < WORDS; w++) words[w] <= '0;
            end else if (wr_en && wr_slot == SLOT_W'(s) && 32'(wr_word) < WORDS) begin
                words[wr_word] <= wr_data;
            end
        end

        // Assemble the slot and compare it with the key.
        always_comb begin
            for (int w = 0; w < WORDS; w++) flat[w*WORD_W +: WORD_W] = words[w];
            hits[s] = (flat == key) && (flat != '0);
        end
    end

    assign hit = |hits;

    // R5
    zero_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (key != '0));

endmodule

// File: rtl/rxf_hash_table.sv
// Multicast hash table stored as 16-bit words. The upper index bits
// pick the word and the lower bits pick the bit.
module rxf_hash_table #(
    parameter int IDX_W  = 9,
    parameter int WORD_W = 16,
    localparam int BIT_W  = $clog2(WORD_W),
    localparam int NWORDS = (1 << IDX_W) / WORD_W,
    localparam int WSEL_W = IDX_W - BIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WSEL_W-1:0] wr_word,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_bit
);
    logic [WORD_W-1:0] tbl [NWORDS];

    // Replace one table word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NWORDS; w++) tbl[w] <= '0;
        end else if (wr_en) begin
            tbl[wr_word] <= wr_data;
        end
    end

    // Select the addressed bit.
    assign rd_bit = tbl[rd_idx[IDX_W-1:BIT_W]][rd_idx[BIT_W-1:0]];

    // R11
    cleared_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data == '0 && rd_idx[IDX_W-1:BIT_W] == wr_word && $stable(rd_idx))
        |=> !rd_bit);

endmodule

// File: rtl/rx_addr_filter.sv
// Receive address filter top. It decodes register writes into the
// exact table, the hash table and the mode bits, then registers an
// accept decision one edge after the address is complete.
// Assumes all writes finish before the address they should affect.
module rx_addr_filter #(
    parameter int EXACT_SLOTS = 16,
    parameter int HASH_IDX_W  = 9,
    localparam int WORD_W  = 16,
    localparam int SLOT_W  = $clog2(EXACT_SLOTS),
    localparam int HWSEL_W = HASH_IDX_W - $clog2(WORD_W),
    localparam int CFG_AW  = SLOT_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              da_valid,
    input  logic              da_sof,
    input  logic [7:0]        da_byte,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic [2:0]        dec_source
);
    import rxf_pkg::*;

    localparam int ADDR_BYTES = 6;
    localparam int AW         = 8 * ADDR_BYTES;

    logic [AW-1:0]         cap_addr;
    logic [HASH_IDX_W-1:0] cap_idx;
    logic                  cap_done;
    logic                  we_exact, we_hash, we_mode;
    logic                  exact_hit, hash_bit;
    logic [2:0]            mode_q;
    logic                  m_promisc, m_allmc, m_bcast;
    logic                  is_bcast, is_mcast;
    match_src_e            src_d;

    // Region decode of the write address.
    always_comb begin
        we_exact = cfg_we && !cfg_addr[CFG_AW-1];
        we_hash  = cfg_we && cfg_addr[CFG_AW-1 -: 2] == 2'b10;
        we_mode  = cfg_we && cfg_addr == {2'b11, {(CFG_AW-2){1'b0}}};
    end

    rxf_addr_capture #(.BYTES(ADDR_BYTES), .IDX_W(HASH_IDX_W)) i_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_vld (da_valid),
        .byte_sof (da_sof),
        .byte_dat (da_byte),
        .addr_q   (cap_addr),
        .hash_idx (cap_idx),
        .done_q   (cap_done)
    );

    rxf_exact_table #(.SLOTS(EXACT_SLOTS), .WORD_W(WORD_W), .WORDS(AW / WORD_W)) i_exact (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (we_exact),
        .wr_slot (cfg_addr[SLOT_W+1:2]),
        .wr_word (cfg_addr[1:0]),
        .wr_data (cfg_wdata),
        .key     (cap_addr),
        .hit     (exact_hit)
    );

    rxf_hash_table #(.IDX_W(HASH_IDX_W), .WORD_W(WORD_W)) i_hash (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (we_hash),
        .wr_word (cfg_addr[HWSEL_W-1:0]),
        .wr_data (cfg_wdata),
        .rd_idx  (cap_idx),
        .rd_bit  (hash_bit)
    );

    // Mode register: bit 0 promiscuous, bit 1 all-multicast, bit 2 broadcast.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (we_mode) mode_q <= cfg_wdata[2:0];
    end

    assign m_promisc = mode_q[0];
    assign m_allmc   = mode_q[1];
    assign m_bcast   = mode_q[2];
    assign is_bcast  = &cap_addr;
    assign is_mcast  = cap_addr[AW-8];

    // Rule priority: exact, broadcast, hash, open modes.
    always_comb begin
        src_d = SRC_NONE;
        if (exact_hit) begin
            src_d = SRC_EXACT;
        end else if (is_bcast) begin
            if (m_bcast)        src_d = SRC_BCAST;
            else if (m_promisc) src_d = SRC_OPEN;
        end else if (is_mcast && hash_bit) begin
            src_d = SRC_HASH;
        end else if (m_promisc || (m_allmc && is_mcast)) begin
            src_d = SRC_OPEN;
        end
    end

    // Register the decision for one cycle after address completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            dec_source <= '0;
        end else if (cap_done) begin
            dec_valid  <= 1'b1;
            dec_accept <= (src_d != SRC_NONE);
            dec_source <= 3'(src_d);
        end else begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            dec_source <= '0;
        end
    end

    // R2
    dec_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(cap_done));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (dec_source == 3'd0 && !dec_accept));

    // R8
    promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && $past(m_promisc)) |-> dec_accept);

    // R4
    exact_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_done && exact_hit) |=> (dec_source == 3'd1));

endmodule

// File: tb/test_rx_addr_filter.sv
module test_rx_addr_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        da_valid = 1'b0;
    logic        da_sof = 1'b0;
    logic [7:0]  da_byte = '0;
    logic        dec_valid, dec_accept;
    logic [2:0]  dec_source;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [47:0] sh_exact [16];
    logic [15:0] sh_hash  [32];
    logic [2:0]  sh_mode;

    always #10 clk = ~clk;

    rx_addr_filter i_rx_addr_filter (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .da_valid(da_valid), .da_sof(da_sof),
        .da_byte(da_byte), .dec_valid(dec_valid), .dec_accept(dec_accept),
        .dec_source(dec_source)
    );

    // Vector table: {mode[2:0], destination[47:0]}; mode b2 bcast, b1 allmc, b0 promisc.
    localparam logic [50:0] VECS [13] = '{
        {3'b100, 48'h021122334455},
        {3'b100, 48'h01005E000007},
        {3'b100, 48'h01005E0000FB},
        {3'b100, 48'hFFFFFFFFFFFF},
        {3'b000, 48'hFFFFFFFFFFFF},
        {3'b001, 48'hFFFFFFFFFFFF},
        {3'b100, 48'h02AABBCCDDEE},
        {3'b001, 48'h02AABBCCDDEE},
        {3'b010, 48'h333300000001},
        {3'b010, 48'h02AABBCCDDEE},
        {3'b101, 48'h021122334455},
        {3'b100, 48'h000000000000},
        {3'b100, 48'h020000000099}
    };

    function automatic logic [8:0] ref_idx(input logic [47:0] a);
        logic [31:0] r = 32'hFFFFFFFF;
        for (int k = 0; k < 48; k++) begin
            logic d = a[47 - 8*(k/8) - 7 + (k%8)];
            logic f = r[31] ^ d;
            r = (r << 1) ^ (f ? 32'h04C11DB7 : 32'h0);
        end
        return r[31:23];
    endfunction

    // Expected {accept, source} from the requirements.
    function automatic logic [3:0] model(input logic [47:0] a);
        logic ex = 1'b0;
        logic mc = a[40];
        logic [8:0] ix = ref_idx(a);
        for (int i = 0; i < 16; i++)
            if (sh_exact[i] != 48'h0 && sh_exact[i] == a) ex = 1'b1;
        if (ex) return {1'b1, 3'd1};
        if (a == 48'hFFFFFFFFFFFF) begin
            if (sh_mode[2]) return {1'b1, 3'd3};
            if (sh_mode[0]) return {1'b1, 3'd4};
            return 4'd0;
        end
        if (mc && sh_hash[ix[8:4]][ix[3:0]]) return {1'b1, 3'd2};
        if (sh_mode[0] || (sh_mode[1] && mc)) return {1'b1, 3'd4};
        return 4'd0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_exact(input int s, input logic [47:0] a);
        wr(7'(s*4 + 0), a[15:0]);
        wr(7'(s*4 + 1), a[31:16]);
        wr(7'(s*4 + 2), a[47:32]);
        sh_exact[s] = a;
    endtask

    task automatic set_hash_word(input int w, input logic [15:0] d);
        wr(7'h40 + 7'(w), d);
        sh_hash[w] = d;
    endtask

    task automatic hash_add(input logic [47:0] a);
        logic [8:0] ix = ref_idx(a);
        logic [15:0] d = sh_hash[ix[8:4]] | (16'h1 << ix[3:0]);
        set_hash_word(int'(ix[8:4]), d);
    endtask

    task automatic set_mode(input logic [2:0] m);
        wr(7'h60, {13'h0, m});
        sh_mode = m;
    endtask

    task automatic drive_bytes(input logic [47:0] a, input int gap);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            da_valid = 1'b1; da_sof = (i == 0); da_byte = a[47 - 8*i -: 8];
            if (i < 5) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    da_valid = 1'b0; da_sof = 1'b0;
                end
            end
        end
    endtask

    // Send an address and check timing and result against the model.
    task automatic decide(input string req, input logic [47:0] a, input int gap);
        logic [3:0] e = model(a);
        drive_bytes(a, gap);
        @(negedge clk);
        da_valid = 1'b0; da_sof = 1'b0;
        check({req, " R2 early"}, dec_valid, 0);
        @(negedge clk);
        check({req, " R2 valid"}, dec_valid, 1);
        check({req, " accept"}, dec_accept, e[3]);
        check({req, " source"}, dec_source, e[2:0]);
        @(negedge clk);
        check({req, " R2 pulse"}, dec_valid, 0);
    endtask

    initial begin
        int pulses;
        logic [3:0] e;
        for (int i = 0; i < 16; i++) sh_exact[i] = '0;
        for (int i = 0; i < 32; i++) sh_hash[i] = '0;
        sh_mode = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", dec_valid, 0);
        check("R1 accept", dec_accept, 0);
        check("R1 source", dec_source, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 / R5: empty tables, zero address is rejected
        decide("R1 R5 empty", 48'h0, 0);

        // Program tables: station in slot 0 (R4), multicast in slot 5
        set_exact(0, 48'h021122334455);
        set_exact(5, 48'h01005E000007);
        hash_add(48'h01005E0000FB);     // R6
        hash_add(48'h020000000099);     // R11 unicast must not hit

        // Table-driven walk: R4 R6 R7 R8 R9 R10 R11 R5
        for (int v = 0; v < 13; v++) begin
            set_mode(VECS[v][50:48]);
            decide($sformatf("R10 vec%0d", v), VECS[v][47:0], v % 3);
        end

        // R2: trailing bytes without start are ignored
        set_mode(3'b100);
        e = model(48'h021122334455);
        drive_bytes(48'h021122334455, 0);
        pulses = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            da_valid = (i < 3); da_sof = 1'b0; da_byte = 8'hA5;
            if (dec_valid) begin
                pulses++;
                check("R2 trailing source", dec_source, e[2:0]);
            end
        end
        da_valid = 1'b0;
        check("R2 trailing pulses", pulses, 1);

        // R3: restart mid-address
        @(negedge clk);
        da_valid = 1'b1; da_sof = 1'b1; da_byte = 8'h02;
        @(negedge clk);
        da_sof = 1'b0; da_byte = 8'h77;
        @(negedge clk);
        da_byte = 8'h88;
        drive_bytes(48'h01005E000007, 0);
        pulses = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            da_valid = 1'b0; da_sof = 1'b0;
            if (dec_valid) begin
                pulses++;
                check("R3 restart source", dec_source, 3'd1);
            end
        end
        check("R3 restart pulses", pulses, 1);

        // R11: clearing the hash word removes the match
        begin
            logic [8:0] ix = ref_idx(48'h01005E0000FB);
            set_hash_word(int'(ix[8:4]), 16'h0);
        end
        decide("R11 cleared", 48'h01005E0000FB, 0);
        e = model(48'h01005E0000FB);
        check("R11 model reject", e, 4'd0);

        // R5: clearing a slot to zero makes it empty
        set_exact(5, 48'h0);
        decide("R5 zeroed slot", 48'h01005E000007, 1);
        decide("R5 zero addr", 48'h0, 0);

        // R4: word 3 writes are ignored
        wr(7'h03, 16'hFFFF);
        decide("R4 word3", 48'h021122334455, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected<=100000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule